// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block keeps the chip's current power mode and turns it into clock-enable outputs. It drives enables for the CPU clock, for a set of peripheral clocks and for the display clock, and a select between the PLL clock and a slow reference clock. Software changes the mode by writing a mode request. The block leaves the low-power modes on interrupts. When it leaves the full-stop mode, it counts a programmable settle interval, so that the clock source has time to recover before the clocks come back on.

Each peripheral has a software clock-enable bit, and the display has one as well. Each of these bits is ANDed with the enable that the current mode implies. The enables are plain logic levels. Real gating cells, the PLL and lock detection sit outside the block.

Top module: `pmc_top`

## Requirements
- R1: While reset is held, and after it is released, the mode is normal (code 0). The CPU, peripheral and display mode enables are then all on, `pll_sel` is 1 and `settling_o` is 0.
- R2: Mode codes are normal=0, slow=1, idle=2, stop=3 and display-only idle=4. A `req_valid` pulse with a legal code sets `mode_o` to that code one cycle later, unless a wake rule below applies in the same cycle.
- R3: A request with code 5, 6 or 7 is ignored, and the current mode and all enables stay as they were.
- R4: In normal mode every clock is enabled and `pll_sel` is 1. In slow mode every clock is enabled and `pll_sel` is 0, so the slow reference clock is selected.
- R5: In idle mode only the CPU clock is disabled. The peripheral and display clocks keep running.
- R6: In stop mode the CPU, peripheral and display enables are all 0.
- R7: In display-only idle mode the display enable follows `disp_sw_en`, and the CPU and all peripheral enables are 0.
- R8: In idle mode, `any_irq` or any wake line (`ext_irq` bit or `alarm_irq`) returns the block to normal one cycle later.
- R9: In stop mode, any set `ext_irq` bit or `alarm_irq` starts a settle phase. During that phase `settling_o` is 1, `mode_o` reads 3 and every clock enable is 0. The phase lasts `settle_val`+1 cycles, and then the mode is normal.
- R10: In stop mode, `any_irq` on its own does not wake the block.
- R11: In display-only idle mode, any set `ext_irq` bit or `alarm_irq` returns the block to normal one cycle later, with no settle phase.
- R12: Each `periph_clk_en[i]` equals `sw_clk_en[i]` AND the peripheral enable of the current mode. `disp_clk_en` equals `disp_sw_en` AND the display enable of the current mode.
- R13: A wake takes precedence over a request made in the same cycle. A request made during the settle phase is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Software mode-request strobe |
| req_mode | input | 3 | Requested mode code |
| settle_val | input | CNT_W | Settle count used on a wake from stop |
| ext_irq | input | N_EXT | External interrupt lines that can wake the block |
| alarm_irq | input | 1 | Alarm interrupt that can wake the block |
| any_irq | input | 1 | Any pending interrupt, used to wake from idle |
| sw_clk_en | input | N_PERIPH | Software clock enable per peripheral |
| disp_sw_en | input | 1 | Software clock enable for the display |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | N_PERIPH | Final clock enable per peripheral |
| disp_clk_en | output | 1 | Final display clock enable |
| pll_sel | output | 1 | 1 selects the PLL clock, 0 selects the slow reference |
| mode_o | output | 3 | Current mode code (reads 3 while settling) |
| settling_o | output | 1 | High during the settle phase after a wake from stop |

## Verification
The assertions check on every cycle that stop and the settle phase keep every enable off. They also check that no peripheral runs without its software bit, that display-only idle leaves the display as the only clock, and that illegal codes leave the mode unchanged. They further check that idle always exits on an interrupt and that the settle counter either continues or exits to normal. Only the bench's scenarios can show that the settle length equals `settle_val`+1 for specific values, including zero. The same holds for wake-versus-request precedence, and for the claim that `any_irq` alone leaves stop untouched over a long window. The bench reaches these through a behavioural reference compared on every clock.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    PM_NORMAL = 3'd0,
    PM_SLOW   = 3'd1,
    PM_IDLE   = 3'd2,
    PM_STOP   = 3'd3,
    PM_DISP   = 3'd4,
    PM_SETTLE = 3'd5
  } pm_state_t;

  typedef struct packed {
    logic cpu;
    logic periph;
    logic disp;
    logic pll;
  } gate_t;

  localparam logic [2:0] MAX_REQ_CODE = 3'd4;

  function automatic logic req_code_ok(input logic [2:0] code);
    return code <= MAX_REQ_CODE;
  endfunction

  function automatic gate_t gates_of(input pm_state_t s);
    gate_t g;
    g.cpu    = (s == PM_NORMAL) || (s == PM_SLOW);
    g.periph = g.cpu || (s == PM_IDLE);
    g.disp   = g.periph || (s == PM_DISP);
    g.pll    = (s != PM_SLOW);
    return g;
  endfunction

  function automatic logic [2:0] visible_code(input pm_state_t s);
    return (s == PM_SETTLE) ? 3'd3 : 3'(s);
  endfunction
endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int N_EXT = 8
) (
  input  logic [N_EXT-1:0] ext_irq,
  input  logic             alarm_irq,
  input  logic             any_irq,
  output logic             stop_wake,
  output logic             idle_wake
);
  logic [N_EXT:0] src;
  assign src = {alarm_irq, ext_irq};

  assign stop_wake = |src;
  assign idle_wake = any_irq | stop_wake;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_mode,
  input  logic [CNT_W-1:0] settle_val,
  input  logic             stop_wake,
  input  logic             idle_wake,
  output pm_state_t        state,
  output logic             req_taken
);
  logic [CNT_W-1:0] cnt, cnt_nxt;
  pm_state_t        nxt;
  logic             req_ok;
  logic             settle_end;

  assign req_ok     = req_valid && req_code_ok(req_mode);
  assign settle_end = (state == PM_SETTLE) && (cnt == '0);

  always_comb begin
    nxt       = state;
    cnt_nxt   = cnt;
    req_taken = 1'b0;
    case (state)
      PM_SETTLE: begin
        if (settle_end) nxt = PM_NORMAL;
        else            cnt_nxt = cnt - 1'b1;
      end
      PM_IDLE: begin
        if (idle_wake) nxt = PM_NORMAL;
        else if (req_ok) begin nxt = pm_state_t'(req_mode); req_taken = 1'b1; end
      end
      PM_STOP: begin
        if (stop_wake) begin nxt = PM_SETTLE; cnt_nxt = settle_val; end
        else if (req_ok) begin nxt = pm_state_t'(req_mode); req_taken = 1'b1; end
      end
      PM_DISP: begin
        if (stop_wake) nxt = PM_NORMAL;
        else if (req_ok) begin nxt = pm_state_t'(req_mode); req_taken = 1'b1; end
      end
      default: begin
        if (req_ok) begin nxt = pm_state_t'(req_mode); req_taken = 1'b1; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PM_NORMAL;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  p_idle_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_IDLE && idle_wake) |=> state == PM_NORMAL);

  p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_code_ok(req_mode) && !idle_wake && state != PM_SETTLE)
      |=> $stable(state));

  p_settle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SETTLE && !settle_end) |=> state == PM_SETTLE);

  p_settle_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    settle_end |=> state == PM_NORMAL);

  p_settle_locked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_SETTLE) |-> !req_taken);

  p_stop_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_STOP && !stop_wake && !req_valid) |=> state == PM_STOP);
endmodule

// File: rtl/pmc_gate_map.sv
module pmc_gate_map
  import pmc_pkg::*;
#(
  parameter int N_PERIPH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pm_state_t           state,
  input  logic [N_PERIPH-1:0] sw_clk_en,
  input  logic                disp_sw_en,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                disp_clk_en,
  output logic                pll_sel
);
  gate_t g;
  assign g = gates_of(state);

  assign cpu_clk_en  = g.cpu;
  assign disp_clk_en = g.disp & disp_sw_en;
  assign pll_sel     = g.pll;

  for (genvar i = 0; i < N_PERIPH; i++) begin : g_periph
    assign periph_clk_en[i] = sw_clk_en[i] & g.periph;
  end

  p_disp_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_DISP) |-> (!cpu_clk_en && periph_clk_en == '0 && disp_clk_en == disp_sw_en));

  p_idle_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_IDLE) |-> (!cpu_clk_en && periph_clk_en == sw_clk_en));
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int N_EXT    = 8,
  parameter int N_PERIPH = 16,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_mode,
  input  logic [CNT_W-1:0]    settle_val,
  input  logic [N_EXT-1:0]    ext_irq,
  input  logic                alarm_irq,
  input  logic                any_irq,
  input  logic [N_PERIPH-1:0] sw_clk_en,
  input  logic                disp_sw_en,
  output logic                cpu_clk_en,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                disp_clk_en,
  output logic                pll_sel,
  output logic [2:0]          mode_o,
  output logic                settling_o
);
  pm_state_t state;
  logic      stop_wake, idle_wake, req_taken;

  pmc_wake #(.N_EXT(N_EXT)) u_wake (
    .ext_irq(ext_irq), .alarm_irq(alarm_irq), .any_irq(any_irq),
    .stop_wake(stop_wake), .idle_wake(idle_wake)
  );

  pmc_mode_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .settle_val(settle_val), .stop_wake(stop_wake), .idle_wake(idle_wake),
    .state(state), .req_taken(req_taken)
  );

  pmc_gate_map #(.N_PERIPH(N_PERIPH)) u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .sw_clk_en(sw_clk_en),
    .disp_sw_en(disp_sw_en), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .disp_clk_en(disp_clk_en), .pll_sel(pll_sel)
  );

  assign mode_o     = visible_code(state);
  assign settling_o = (state == PM_SETTLE);

  p_stop_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3) |-> (!cpu_clk_en && !disp_clk_en && periph_clk_en == '0));

  p_periph_needs_sw_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_clk_en & ~sw_clk_en) == '0);

  p_slow_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_sel) |-> (mode_o == 3'd1 && cpu_clk_en));

  p_taken_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_taken |=> mode_o == $past(req_mode));
endmodule

// File: tb/tb_pmc_top.sv
module tb_pmc_top;
  localparam int N_EXT = 8, N_PERIPH = 16, CNT_W = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_mode = 0;
  logic [CNT_W-1:0] settle_val = 0;
  logic [N_EXT-1:0] ext_irq = 0;
  logic alarm_irq = 0, any_irq = 0;
  logic [N_PERIPH-1:0] sw_clk_en = '1;
  logic disp_sw_en = 1;
  logic cpu_clk_en, disp_clk_en, pll_sel, settling_o;
  logic [N_PERIPH-1:0] periph_clk_en;
  logic [2:0] mode_o;

  pmc_top #(.N_EXT(N_EXT), .N_PERIPH(N_PERIPH), .CNT_W(CNT_W)) dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference: m = mode number, 5 stands for the settle phase
  int m = 0, left = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m = 0; left = 0; end
    else if (m == 5) begin if (left == 0) m = 0; else left = left - 1; end
    else if (m == 2 && (any_irq || ext_irq != 0 || alarm_irq)) m = 0;
    else if (m == 3 && (ext_irq != 0 || alarm_irq)) begin m = 5; left = int'(settle_val); end
    else if (m == 4 && (ext_irq != 0 || alarm_irq)) m = 0;
    else if (req_valid && req_mode < 5) m = int'(req_mode);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic pe;
    pe = (m <= 2);
    chk(cur_req, 32'(cpu_clk_en), 32'(m <= 1));
    chk(cur_req, 32'(periph_clk_en), 32'(sw_clk_en & {N_PERIPH{pe}}));
    chk(cur_req, 32'(disp_clk_en), 32'(disp_sw_en && (pe || m == 4)));
    chk(cur_req, 32'(pll_sel), 32'(m != 1));
    chk(cur_req, 32'(mode_o), (m == 5) ? 32'd3 : 32'(m));
    chk(cur_req, 32'(settling_o), 32'(m == 5));
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic request(input logic [2:0] code);
    req_valid = 1; req_mode = code; tick(); req_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk); #1;
    chk("R1", 32'(mode_o), 0); chk("R1", 32'(cpu_clk_en), 1);
    chk("R1", 32'(pll_sel), 1); chk("R1", 32'(settling_o), 0);
    rst_n = 1; tick();
    chk("R1", 32'(disp_clk_en), 1);

    cur_req = "R4"; request(3'd1);
    chk("R4", 32'(pll_sel), 0); chk("R2", 32'(mode_o), 1); chk("R4", 32'(cpu_clk_en), 1);
    request(3'd0); chk("R4", 32'(pll_sel), 1);

    cur_req = "R3";
    for (int c = 5; c < 8; c++) begin
      request(3'(c)); chk("R3", 32'(mode_o), 0); chk("R3", 32'(cpu_clk_en), 1);
    end

    cur_req = "R12"; sw_clk_en = 16'hA5C3; #1;
    chk("R12", 32'(periph_clk_en), 32'h0000A5C3);
    disp_sw_en = 0; #1; chk("R12", 32'(disp_clk_en), 0); disp_sw_en = 1;

    cur_req = "R5"; request(3'd2);
    chk("R5", 32'(cpu_clk_en), 0); chk("R5", 32'(periph_clk_en), 32'h0000A5C3);
    chk("R5", 32'(disp_clk_en), 1);
    sw_clk_en = 16'h0F0F; #1; chk("R12", 32'(periph_clk_en), 32'h00000F0F);
    repeat (3) tick();
    cur_req = "R8"; any_irq = 1; tick(); any_irq = 0;
    chk("R8", 32'(mode_o), 0); chk("R8", 32'(cpu_clk_en), 1);

    cur_req = "R13"; request(3'd2);
    req_valid = 1; req_mode = 3'd3; any_irq = 1; tick(); req_valid = 0; any_irq = 0;
    chk("R13", 32'(mode_o), 0);

    cur_req = "R6"; request(3'd3);
    chk("R6", 32'(cpu_clk_en), 0); chk("R6", 32'(periph_clk_en), 0); chk("R6", 32'(disp_clk_en), 0);
    cur_req = "R10"; any_irq = 1; repeat (5) tick(); any_irq = 0;
    chk("R10", 32'(mode_o), 3); chk("R10", 32'(settling_o), 0);

    cur_req = "R9"; settle_val = 8'd3; ext_irq = 8'h20; tick(); ext_irq = 0;
    chk("R9", 32'(settling_o), 1); chk("R9", 32'(mode_o), 3);
    for (int k = 0; k < 3; k++) begin
      tick(); chk("R9", 32'(settling_o), 1); chk("R9", 32'(cpu_clk_en), 0);
    end
    tick(); chk("R9", 32'(mode_o), 0); chk("R9", 32'(settling_o), 0);

    request(3'd3); settle_val = 8'd0; alarm_irq = 1; tick(); alarm_irq = 0;
    chk("R9", 32'(settling_o), 1);
    tick(); chk("R9", 32'(mode_o), 0);

    cur_req = "R13"; request(3'd3); settle_val = 8'd4; ext_irq = 8'h01; tick(); ext_irq = 0;
    request(3'd1); chk("R13", 32'(mode_o), 3); chk("R13", 32'(settling_o), 1);
    repeat (4) tick(); chk("R13", 32'(mode_o), 0); chk("R13", 32'(pll_sel), 1);

    cur_req = "R7"; request(3'd4);
    chk("R7", 32'(disp_clk_en), 1); chk("R7", 32'(cpu_clk_en), 0); chk("R7", 32'(periph_clk_en), 0);
    disp_sw_en = 0; #1; chk("R7", 32'(disp_clk_en), 0); disp_sw_en = 1;
    any_irq = 1; tick(); any_irq = 0; chk("R7", 32'(mode_o), 4);
    cur_req = "R11"; ext_irq = 8'h80; tick(); ext_irq = 0;
    chk("R11", 32'(mode_o), 0); chk("R11", 32'(settling_o), 0);

    cur_req = "R2"; request(3'd1); request(3'd2); chk("R2", 32'(mode_o), 2);
    request(3'd4); chk("R2", 32'(mode_o), 4);
    alarm_irq = 1; tick(); alarm_irq = 0; chk("R11", 32'(mode_o), 0);
    repeat (3) tick();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule